// File: doc/BRIEF.md
# ISA Extension Enable Register

This block holds the set of single-letter instruction-set extensions that are active in a core. There is one enable bit for each letter of the alphabet. The bit for a letter sits at position (letter − 'A'), so A is bit 0, C is bit 2, D is bit 3, F is bit 5, I is bit 8, M is bit 12, S is bit 18, U is bit 20 and X is bit 23.

An elaboration-time capability mask states which extensions the core can provide. Reset loads that mask as the current enable set. Control software may then switch a small group of extensions off and on again at run time through a register write port. A combinational read port returns the current set. The same value is also driven onto a vector of per-extension enable lines for the rest of the core.

Only five letters can be changed: multiply (M), atomics (A), single float (F), double float (D) and compressed (C). Each of them can change only when the capability mask contains it. Double float depends on single float: a write that clears F also clears D. The supervisor (S) and user (U) bits always read as set.

Top module: `isa_ext_reg`

## Requirements
- R1: After reset the read value equals the capability mask with bits S (18) and U (20) also set.
- R2: Bits S (18) and U (20) read as 1 at all times after reset, whatever is written.
- R3: When wr_en_i is high at a rising edge, each of bits M (12), A (0), F (5), D (3) and C (2) that is set in the capability mask takes the written value from that edge on.
- R4: A bit that is clear in the capability mask never reads as 1, except S and U. This holds even when a write sets it.
- R5: Every bit other than M, A, F, D and C keeps its value across a write, whatever the write data holds in that position.
- R6: A write whose bit F (5) is 0 leaves bit D (3) at 0, even when the written D is 1.
- R7: When wr_en_i is low at a rising edge, the read value does not change.
- R8: ext_en_o always equals rd_data_o.
- R9: The read value is combinational from the stored state. A write is visible on rd_data_o in the cycle after the edge that takes it, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, taken at the rising edge |
| wr_data_i | input | 26 | Write value, bit n for letter 'A'+n |
| rd_data_o | output | 26 | Current enable set, with S and U forced to 1 |
| ext_en_o | output | 26 | Per-extension enable lines to the core |

## Verification
A wrong stored bit appears on rd_data_o and ext_en_o in the very next cycle, because nothing sits between the state and the ports. A filter fault shows in the read taken right after the faulty write. Such faults include a wrong writable mask, a missing capability gate or a missing F-to-D dependency. A write that leaks while the strobe is low shows one cycle later. The bench sweeps every combination of the five writable bits, with varied surrounding data, so every path through the write filter is compared against an arithmetic model.

// File: rtl/isa_ext_pkg.sv
package isa_ext_pkg;
  localparam int unsigned NUM_LETTERS = 26;
  typedef logic [NUM_LETTERS-1:0] ext_vec_t;

  localparam int unsigned IDX_A = 0;
  localparam int unsigned IDX_C = 2;
  localparam int unsigned IDX_D = 3;
  localparam int unsigned IDX_F = 5;
  localparam int unsigned IDX_I = 8;
  localparam int unsigned IDX_M = 12;
  localparam int unsigned IDX_S = 18;
  localparam int unsigned IDX_U = 20;

  function automatic ext_vec_t ext_bit(int unsigned idx);
    ext_vec_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  localparam ext_vec_t RUNTIME_MASK = ext_bit(IDX_M) | ext_bit(IDX_A) | ext_bit(IDX_F)
                                    | ext_bit(IDX_D) | ext_bit(IDX_C);
  localparam ext_vec_t ALWAYS_ON    = ext_bit(IDX_S) | ext_bit(IDX_U);
endpackage

// File: rtl/isa_ext_wr_filter.sv
module isa_ext_wr_filter
  import isa_ext_pkg::*;
#(
  parameter ext_vec_t CAP_MASK = '0
) (
  input  ext_vec_t cur_i,
  input  ext_vec_t wr_data_i,
  output ext_vec_t next_o
);
  localparam ext_vec_t GATE = RUNTIME_MASK & CAP_MASK;

  ext_vec_t dep_fixed;

  // double float needs single float
  always_comb begin
    dep_fixed = wr_data_i;
    if (!wr_data_i[IDX_F]) dep_fixed[IDX_D] = 1'b0;
  end

  for (genvar i = 0; i < NUM_LETTERS; i++) begin : g_bit
    if (GATE[i]) begin : g_rw
      assign next_o[i] = dep_fixed[i];
    end else begin : g_ro
      assign next_o[i] = cur_i[i];
    end
  end
endmodule

// File: rtl/isa_ext_state.sv
module isa_ext_state
  import isa_ext_pkg::*;
#(
  parameter ext_vec_t CAP_MASK = '0
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_en_i,
  input  logic     wr_f_i,
  input  ext_vec_t next_i,
  output ext_vec_t cur_o
);
  ext_vec_t cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cur_q <= CAP_MASK;
    else if (wr_en_i) cur_q <= next_i;
  end

  assign cur_o = cur_q;

  // R7
  hold_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cur_q));

  // R5
  fixed_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(cur_q & ~RUNTIME_MASK));

  // R6
  d_needs_f_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_f_i) |=> !cur_q[IDX_D]);

  // R4
  within_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q & ~CAP_MASK) == '0);
endmodule

// File: rtl/isa_ext_reg.sv
module isa_ext_reg
  import isa_ext_pkg::*;
#(
  parameter ext_vec_t MAX_EXT_MASK = ext_bit(IDX_I) | ext_bit(IDX_M) | ext_bit(IDX_A)
                                   | ext_bit(IDX_F) | ext_bit(IDX_D) | ext_bit(IDX_C)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [NUM_LETTERS-1:0] wr_data_i,
  output logic [NUM_LETTERS-1:0] rd_data_o,
  output logic [NUM_LETTERS-1:0] ext_en_o
);
  ext_vec_t cur, next_val;

  isa_ext_wr_filter #(.CAP_MASK(MAX_EXT_MASK)) u_filter (
    .cur_i     (cur),
    .wr_data_i (wr_data_i),
    .next_o    (next_val)
  );

  isa_ext_state #(.CAP_MASK(MAX_EXT_MASK)) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .wr_f_i  (wr_data_i[IDX_F]),
    .next_i  (next_val),
    .cur_o   (cur)
  );

  assign rd_data_o = cur | ALWAYS_ON;
  assign ext_en_o  = rd_data_o;

  // R2
  su_report_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[IDX_S] && rd_data_o[IDX_U]);

  // R3
  m_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[IDX_M] == ($past(wr_data_i[IDX_M]) & MAX_EXT_MASK[IDX_M])
                || !MAX_EXT_MASK[IDX_M]);
endmodule

// File: tb/isa_ext_reg_test.sv
`timescale 1ns/1ps
module isa_ext_reg_test;
  import isa_ext_pkg::*;

  // capability without C, with X (23)
  localparam logic [25:0] CAP = 26'h080_1129;
  localparam logic [25:0] SU  = 26'h014_0000;
  localparam logic [25:0] WR  = 26'h000_102D; // M A F D C

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [25:0] wr_data = '0;
  logic [25:0] rd_data, ext_en;
  logic [25:0] model;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  isa_ext_reg #(.MAX_EXT_MASK(CAP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .ext_en_o(ext_en)
  );

  task automatic chk(string req, logic [25:0] act, logic [25:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic write(logic en, logic [25:0] d);
    logic [25:0] v;
    @(negedge clk);
    wr_en = en; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (en) begin
      v = d;
      if (!d[5]) v[3] = 1'b0;
      model = (model & ~(WR & CAP)) | (v & WR & CAP);
    end
  endtask

  initial begin
    model = CAP;
    #20; rst_n = 1;
    @(negedge clk);
    chk("R1 reset value", rd_data, CAP | SU);
    chk("R8 enable lines", ext_en, CAP | SU);

    // R6: D written 1 with F 0
    write(1'b1, 26'h000_0008);
    chk("R6 D forced off", rd_data & 26'h28, 26'h0);
    // R4: set C and every other bit, absent ones stay off
    write(1'b1, 26'h3FF_FFFF);
    chk("R4 absent stay off", rd_data & ~(CAP | SU), 26'h0);
    chk("R3 all present on", rd_data, model | SU);

    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 32; k++) begin
        logic [25:0] d;
        d = (p == 0) ? 26'h0 : (p == 1) ? 26'h3FF_FFFF : 26'($urandom);
        d[12] = k[0]; d[0] = k[1]; d[5] = k[2]; d[3] = k[3]; d[2] = k[4];
        write(1'b1, d);
        chk("R3 R5 R6 write sweep", rd_data, model | SU);
        chk("R2 S and U set", rd_data & SU, SU);
        chk("R8 enable lines", ext_en, rd_data);
        // R7: strobe low, opposite data
        write(1'b0, ~d);
        chk("R7 no strobe hold", rd_data, model | SU);
      end
    end

    // R5: fixed bits (I, X) unchanged by zero write
    write(1'b1, 26'h0);
    chk("R5 fixed bits kept", rd_data & ~WR, (CAP & ~WR) | SU);
    // R9: visible right after the edge
    @(negedge clk); wr_en = 1; wr_data = 26'h000_1021;
    @(posedge clk); #1;
    wr_en = 0;
    chk("R9 same cycle read", rd_data, (CAP & ~WR) | 26'h000_1021 | SU);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule